// File: doc/BRIEF.md
# I2C Master Serial Clock Phase Generator

This block produces the serial clock for an I2C master from the system clock. Two 8-bit width settings, one for the low phase and one for the high phase, set how many system clock cycles each phase lasts. While the low phase runs, a one-cycle strobe tells the data path when it may change SDA. That point is one quarter of the way into the low phase. A second one-cycle strobe marks each point where SCL goes high again, so that a shifter can sample SDA there.

The width settings can be written only while the generator is disabled. Once it is enabled, the first phase is high. After that, low and high phases alternate. During a high phase the generator watches the actual line level. If a slave holds SCL low, the high-width count waits until the line is seen high. Start and stop conditions, byte shifting, acknowledge, arbitration and slave timing all belong to neighbouring logic.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset both width settings are 255, so the first enabled run has low and high phases of 256 cycles each and the SDA strobe at low-phase index 63.
- R2: A write (`wr_sel` 0 selects the low width, 1 the high width) is accepted only while `enable` is 0. A write made while `enable` is 1 leaves both settings unchanged.
- R3: While disabled or in reset, `scl_drive_low`, `sda_upd` and `scl_rise` are all 0.
- R4: After `enable` rises, the first phase is a high phase of high-width + 1 cycles, and `scl_rise` does not pulse in it.
- R5: Every low phase lasts low-width + 1 cycles, with `scl_drive_low` at 1.
- R6: Every high phase that follows a low phase lasts high-width + 1 cycles when the line is not held low.
- R7: `sda_upd` pulses exactly once in each low phase, at zero-based cycle index floor(low-width / 4). For low widths below 4 this is index 0.
- R8: While `scl_in` is sampled low during a high phase, the high-width count is held. A high phase stretched for S cycles (S ≥ 1) lasts S + high-width cycles in total.
- R9: `scl_rise` pulses exactly once per high phase that follows a low phase, in the first cycle in which `scl_in` is seen high.
- R10: Clearing `enable` in the middle of a phase releases SCL on the next cycle. A later enable starts again with a full first high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Generator enable; also locks the width settings |
| wr_en | input | 1 | Width-setting write strobe |
| wr_sel | input | 1 | Write target: 0 low width, 1 high width |
| wr_data | input | 8 | Width value to write |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_upd | output | 1 | One-cycle strobe: SDA may change now |
| scl_rise | output | 1 | One-cycle strobe at each SCL rising edge |

## Verification
The bench aims at the small low widths where the quarter truncates to 0. A hold point taken from the wrong bits would put the SDA strobe late, or drop it, in these phases. It sets both widths to 0, where an off-by-one would give phases of zero or two cycles. It writes new values while the generator is enabled. A design without the lock would change period partway through the run. It stretches the high phase. A generator that ignores the line would end the high phase early or fire `scl_rise` while the line is still low. It also disables partway through a low phase. A design that kept its state there would resume mid-phase instead of starting with a full high phase.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } scl_phase_e;

    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } width_sel_e;

endpackage

// File: rtl/scl_width_regs.sv
module scl_width_regs #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] low_width,
    output logic [W-1:0] high_width
);
    import scl_pkg::*;

    localparam logic [W-1:0] RESET_VAL = '1;

    typedef struct packed {
        logic [W-1:0] lo;
        logic [W-1:0] hi;
    } widths_t;

    widths_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (wr_en && !enable) begin
            if (width_sel_e'(wr_sel) == SEL_HIGH) begin
                w_d.hi = wr_data;
            end else begin
                w_d.lo = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.lo <= RESET_VAL;
            w_q.hi <= RESET_VAL;
        end else begin
            w_q <= w_d;
        end
    end

    assign low_width  = w_q.lo;
    assign high_width = w_q.hi;

endmodule

// File: rtl/scl_hold_calc.sv
module scl_hold_calc #(
    parameter int unsigned W          = 8,
    parameter int unsigned HOLD_SHIFT = 2
) (
    input  logic [W-1:0] low_width,
    output logic [W-1:0] hold_cnt
);
    generate
        if (HOLD_SHIFT == 0) begin : g_full
            assign hold_cnt = low_width;
        end else begin : g_frac
            // only the upper bits matter: truncating fraction of the low width
            assign hold_cnt = low_width >> HOLD_SHIFT;
        end
    endgenerate

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         scl_in,
    input  logic [W-1:0] low_width,
    input  logic [W-1:0] high_width,
    input  logic [W-1:0] hold_cnt,
    output logic         scl_drive_low,
    output logic         sda_upd,
    output logic         scl_rise
);
    import scl_pkg::*;

    localparam logic [W-1:0] CNT_ONE = W'(1);

    typedef struct packed {
        scl_phase_e   phase;
        logic [W-1:0] cnt;
        logic         from_low;
    } gen_state_t;

    gen_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                st_d.cnt      = '0;
                st_d.from_low = 1'b0;
                st_d.phase    = PH_HIGH;
            end
            PH_HIGH: begin
                if (scl_in) begin
                    if (st_q.cnt == high_width) begin
                        st_d.phase = PH_LOW;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_ONE;
                    end
                end
            end
            PH_LOW: begin
                if (st_q.cnt == low_width) begin
                    st_d.phase    = PH_HIGH;
                    st_d.cnt      = '0;
                    st_d.from_low = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
        if (!enable) begin
            st_d.phase    = PH_IDLE;
            st_d.cnt      = '0;
            st_d.from_low = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.cnt      <= '0;
            st_q.from_low <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_drive_low = (st_q.phase == PH_LOW);
    assign sda_upd       = (st_q.phase == PH_LOW) && (st_q.cnt == hold_cnt);
    assign scl_rise      = (st_q.phase == PH_HIGH) && st_q.from_low
                           && (st_q.cnt == '0) && scl_in;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned HOLD_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             sda_upd,
    output logic             scl_rise
);
    logic [WIDTH-1:0] low_width;
    logic [WIDTH-1:0] high_width;
    logic [WIDTH-1:0] hold_cnt;

    scl_width_regs #(.W(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .low_width (low_width),
        .high_width(high_width)
    );

    scl_hold_calc #(.W(WIDTH), .HOLD_SHIFT(HOLD_SHIFT)) u_hold (
        .low_width(low_width),
        .hold_cnt (hold_cnt)
    );

    scl_phase_fsm #(.W(WIDTH)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .scl_in       (scl_in),
        .low_width    (low_width),
        .high_width   (high_width),
        .hold_cnt     (hold_cnt),
        .scl_drive_low(scl_drive_low),
        .sda_upd      (sda_upd),
        .scl_rise     (scl_rise)
    );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         enable,
    input logic         wr_en,
    input logic         scl_in,
    input logic         scl_drive_low,
    input logic         sda_upd,
    input logic         scl_rise,
    input logic [W-1:0] low_width,
    input logic [W-1:0] high_width
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !sda_upd && !scl_rise)); // R3

    AST_LOCKED_WIDTHS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_en) |=> ($stable(low_width) && $stable(high_width))); // R2

    AST_SDA_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_upd |-> scl_drive_low); // R7

    AST_SDA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sda_upd |=> !sda_upd); // R7

    AST_RISE_ON_HIGH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (!scl_drive_low && scl_in)); // R9

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> !scl_rise); // R9

endmodule

bind scl_timing_gen scl_timing_chk #(.W(WIDTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .wr_en        (wr_en),
    .scl_in       (scl_in),
    .scl_drive_low(scl_drive_low),
    .sda_upd      (sda_upd),
    .scl_rise     (scl_rise),
    .low_width    (low_width),
    .high_width   (high_width)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       scl_drive_low;
    logic       sda_upd;
    logic       scl_rise;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign scl_in = ~scl_drive_low & ~stretch;

    scl_timing_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .scl_in       (scl_in),
        .scl_drive_low(scl_drive_low),
        .sda_upd      (sda_upd),
        .scl_rise     (scl_rise)
    );

    function automatic int exp_phase(int w);
        return w + 1;
    endfunction

    function automatic int exp_hold(int wl);
        return wl / 4;
    endfunction

    task automatic chk_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(bit sel, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_idle(string req);
        chk_eq({req, " scl released"}, int'(scl_drive_low), 0);
        chk_eq({req, " no sda strobe"}, int'(sda_upd), 0);
        chk_eq({req, " no rise strobe"}, int'(scl_rise), 0);
    endtask

    // enable, measure first high phase and nper low/high pairs; ends on a low sample
    task automatic run_en(string tag, int wl, int wh, int nper, bit poke);
        int hi_n, lo_n, sda_n, sda_at, rise_n, rise_first;
        @(negedge clk);
        enable = 1'b1;
        hi_n = 0; rise_n = 0;
        forever begin
            @(negedge clk);
            if (scl_drive_low) break;
            hi_n++;
            if (scl_rise) rise_n++;
        end
        chk_eq({tag, " R4 first high length"}, hi_n, exp_phase(wh));
        chk_eq({tag, " R4 no rise in first high"}, rise_n, 0);
        for (int p = 0; p < nper; p++) begin
            lo_n = 0; sda_n = 0; sda_at = -1;
            while (scl_drive_low) begin
                if (poke && p == 0) begin
                    if (lo_n == 0) begin
                        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'(wl + 17);
                    end else if (lo_n == 1) begin
                        wr_sel = 1'b1; wr_data = 8'(wh + 9);
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                if (sda_upd) begin sda_n++; sda_at = lo_n; end
                lo_n++;
                @(negedge clk);
            end
            wr_en = 1'b0;
            chk_eq({tag, " R5 low length"}, lo_n, exp_phase(wl));
            chk_eq({tag, " R7 sda strobe count"}, sda_n, 1);
            chk_eq({tag, " R7 sda strobe index"}, sda_at, exp_hold(wl));
            hi_n = 0; rise_n = 0; rise_first = 0;
            while (!scl_drive_low) begin
                if (scl_rise) begin
                    rise_n++;
                    if (hi_n == 0) rise_first = 1;
                end
                hi_n++;
                @(negedge clk);
            end
            chk_eq({tag, " R6 high length"}, hi_n, exp_phase(wh));
            chk_eq({tag, " R9 rise count"}, rise_n, 1);
            chk_eq({tag, " R9 rise on first high cycle"}, rise_first, 1);
        end
    endtask

    // disable in the first cycle of a low phase
    task automatic stop_mid_low();
        enable = 1'b0;
        @(negedge clk);
        check_idle("R10 after mid-low disable");
        repeat (3) @(negedge clk);
        check_idle("R3 disabled");
    endtask

    task automatic run_stretch(int wl, int wh, int s);
        int hi_n;
        @(negedge clk);
        enable = 1'b1;
        while (!scl_drive_low) @(negedge clk);
        stretch = 1'b1;
        while (scl_drive_low) @(negedge clk);
        hi_n = 0;
        for (int i = 1; i <= s; i++) begin
            if (i == 1) chk_eq("R9 no rise while line held low", int'(scl_rise), 0);
            if (i == s) begin
                stretch = 1'b0;
                #1;
                chk_eq("R9 rise when line released", int'(scl_rise), 1);
            end
            hi_n++;
            @(negedge clk);
        end
        while (!scl_drive_low) begin
            hi_n++;
            @(negedge clk);
        end
        chk_eq("R8 stretched high length", hi_n, s + wh);
        lo_check: begin
            int lo_n;
            lo_n = 0;
            while (scl_drive_low) begin lo_n++; @(negedge clk); end
            chk_eq("R5 low length after stretch", lo_n, exp_phase(wl));
        end
        while (!scl_drive_low) @(negedge clk);
        stop_mid_low();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int wl, wh;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        check_idle("R3 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("R3 after reset");

        // R1: reset widths
        run_en("R1", 255, 255, 1, 1'b0);
        stop_mid_low();

        // R7 / R5 / R6 corners: zero widths, truncating quarter
        write_reg(1'b0, 0); write_reg(1'b1, 0);
        run_en("zero", 0, 0, 3, 1'b0);
        stop_mid_low();
        write_reg(1'b0, 3); write_reg(1'b1, 1);
        run_en("wl3", 3, 1, 2, 1'b0);
        stop_mid_low();
        write_reg(1'b0, 4); write_reg(1'b1, 2);
        run_en("wl4", 4, 2, 2, 1'b0);
        stop_mid_low();
        write_reg(1'b0, 7); write_reg(1'b1, 5);
        run_en("wl7", 7, 5, 2, 1'b0);
        stop_mid_low();

        // R2: writes while enabled are dropped, then proven dropped on a fresh run
        write_reg(1'b0, 6); write_reg(1'b1, 3);
        run_en("R2 during", 6, 3, 3, 1'b1);
        stop_mid_low();
        run_en("R2 after", 6, 3, 2, 1'b0);
        stop_mid_low();

        // R8: stretched high phase
        write_reg(1'b0, 2); write_reg(1'b1, 3);
        run_stretch(2, 3, 5);

        // random widths
        for (int k = 0; k < 8; k++) begin
            wl = $urandom_range(0, 23);
            wh = $urandom_range(0, 23);
            write_reg(1'b0, wl);
            write_reg(1'b1, wh);
            run_en("rand", wl, wh, 2, 1'b0);
            stop_mid_low();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule